// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a 32-bit register bus and a one-time-programmable fuse array. Software picks a fuse word through a control register, loads a three-field timing register with cycle counts, and then starts either a sense (a read of the fuse word) or a program operation. For each operation the controller runs a relax phase, an active strobe phase and a second relax phase, each timed by a cycle counter. It drives the array's address, strobe, program-enable and write-data pins, and it captures the sensed word into a read-back register.

Programming needs a 16-bit unlock key in the control register. The key is wiped when any operation finishes, so every program operation needs a fresh unlock. Requests that are not allowed start nothing and set a sticky error flag. Only a write to the clear alias of the control register resets that flag. The fuse cells are assumed to change only from 0 to 1, so programming ORs the new value into the stored word.

Top module: `otp_fuse_ctl`

## Requirements
- R1: After reset the control, timing and read-data registers read 0, and `fuse_strobe` and `fuse_prog_en` are low.
- R2: Control register (write offset 0x00, read offsets 0x00/0x04/0x08): bits 31:16 are the unlock key, bit 9 is the error flag, bit 8 is busy, bits 6:0 are the fuse address (bank*8+word). Bits 15:10 and 7 read 0. A write to 0x00 loads only the key and the address. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: The timing register at 0x10 holds the read strobe count S_r in bits 21:16, the relax count R in bits 15:12 and the program strobe count S_p in bits 11:0. All other bits read 0.
- R4: Writing 1 to bit 0 of the read-control register (0x20) starts a sense. Busy rises in the next cycle and stays high for 2(R+1)+W cycles. `fuse_strobe` rises after R+1 busy cycles and stays high for W = max(1, S_r+1-2(R+1)) cycles. A write there with bit 0 clear starts nothing.
- R5: When busy falls after a sense, the read-data register (0x24) holds the fuse word at the addressed location.
- R6: With the key equal to 0x3E77, a write to 0x28 starts programming with that value, timed as in R4 with S_p. `fuse_prog_en` is high on every busy cycle and `fuse_wdata` carries the value. The word then senses as its old value ORed with the written value.
- R7: A write to 0x28 while the key is not 0x3E77 starts nothing, sets the error flag, and leaves the fuse word unchanged.
- R8: A sense or program request made while busy sets the error flag and changes neither the running operation's length nor its write data.
- R9: The error flag is sticky. A write to the clear alias (0x08) with bit 9 set clears it. Bit 9 written at 0x00 has no effect on it.
- R10: When any operation completes, the key field reads 0.
- R11: Writing to the set alias 0x04 ORs the written bits into the key and address fields. Writing to the clear alias 0x08 clears the written bits in those fields.
- R12: Writes to the control register, its aliases' key and address bits, and the timing register are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_waddr | input | 8 | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 8 | Read byte offset |
| bus_rdata | output | 32 | Registered read data, one cycle after `bus_rd` |
| fuse_addr | output | 7 | Fuse word address |
| fuse_strobe | output | 1 | Active strobe to the array |
| fuse_prog_en | output | 1 | Program enable, high for a whole program operation |
| fuse_wdata | output | 32 | Data to program |
| fuse_rdata | input | 32 | Sensed word from the array |

## Verification
The bench sweeps the relax and strobe counts, including settings where the strobe count is shorter than two relax periods. A controller that let the active width go to zero or negative would then hang or skip the strobe. It measures the strobe lead and width cycle by cycle, so an off-by-one in the two relax phases or the active phase shows up as a wrong count. It injects requests and register writes in the middle of an operation; a design that restarted, stretched, or took a new address or write data would change the measured length or the stored word. It also programs with a wrong key and checks the error clear through both addresses, catching a missing lock, an error flag that clears at the wrong address, and a key that survives completion.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_SET    = 8'h04;
    localparam logic [7:0] OFS_CLR    = 8'h08;
    localparam logic [7:0] OFS_TIMING = 8'h10;
    localparam logic [7:0] OFS_RDCTL  = 8'h20;
    localparam logic [7:0] OFS_RDATA  = 8'h24;
    localparam logic [7:0] OFS_PDATA  = 8'h28;

    // field positions
    localparam int KEY_LSB   = 16;
    localparam int ERR_BIT   = 9;
    localparam int BUSY_BIT  = 8;
    localparam int TRD_LSB   = 16;
    localparam int TRX_LSB   = 12;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_ACT  = 2'd2,
        PH_POST = 2'd3
    } phase_e;

endpackage

// File: rtl/fuse_req_gate.sv
module fuse_req_gate (
    input  logic busy_i,
    input  logic key_ok_i,
    input  logic sense_req_i,
    input  logic prog_req_i,
    output logic start_sense_o,
    output logic start_prog_o,
    output logic err_set_o
);

    always_comb begin
        start_sense_o = sense_req_i && !busy_i;
        start_prog_o  = prog_req_i && !busy_i && key_ok_i;
        err_set_o     = ((sense_req_i || prog_req_i) && busy_i) ||
                        (prog_req_i && !key_ok_i);
    end

endmodule

// File: rtl/fuse_phase_seq.sv
module fuse_phase_seq #(
    parameter int RELAX_W = 4,
    parameter int STB_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               prog_i,
    input  logic [RELAX_W-1:0] relax_i,
    input  logic [STB_W-1:0]   stb_i,
    output logic               busy_o,
    output logic               strobe_o,
    output logic               prog_en_o,
    output logic               capture_o,
    output logic               done_o
);
    import fuse_ctl_pkg::*;

    localparam int CNT_W = STB_W + 2;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   act_len;
        logic [RELAX_W-1:0] relax;
        logic               prog;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [CNT_W-1:0] total_c;
    logic [CNT_W-1:0] two_relax_c;
    logic [CNT_W-1:0] width_c;

    always_comb begin
        total_c     = CNT_W'(stb_i) + CNT_W'(1);
        two_relax_c = (CNT_W'(relax_i) + CNT_W'(1)) << 1;
        width_c     = (total_c > two_relax_c) ? (total_c - two_relax_c) : CNT_W'(1);

        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase   = PH_PRE;
                    seq_d.cnt     = CNT_W'(relax_i);
                    seq_d.act_len = width_c;
                    seq_d.relax   = relax_i;
                    seq_d.prog    = prog_i;
                end
            end
            PH_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_ACT;
                    seq_d.cnt   = seq_q.act_len - CNT_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_ACT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_POST;
                    seq_d.cnt   = CNT_W'(seq_q.relax);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_POST: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.prog  = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        busy_o    = seq_q.phase != PH_IDLE;
        strobe_o  = seq_q.phase == PH_ACT;
        prog_en_o = seq_q.prog && (seq_q.phase != PH_IDLE);
        capture_o = (seq_q.phase == PH_ACT) && (seq_q.cnt == '0) && !seq_q.prog;
        done_o    = (seq_q.phase == PH_POST) && (seq_q.cnt == '0);
    end

    // a leading relax phase always precedes the strobe
    assert_lead_relax_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !strobe_o);

    // a trailing relax phase always follows the strobe
    assert_tail_relax_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_o) |-> busy_o);

    // program enable does not toggle inside one operation
    assert_prog_en_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(prog_en_o));

endmodule

// File: rtl/otp_fuse_ctl.sv
module otp_fuse_ctl #(
    parameter int FADDR_W = 7,
    parameter int RELAX_W = 4,
    parameter int RSTB_W  = 6,
    parameter int PSTB_W  = 12,
    parameter int BUS_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_waddr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_rd,
    input  logic [BUS_AW-1:0]  bus_raddr,
    output logic [31:0]        bus_rdata,
    output logic [FADDR_W-1:0] fuse_addr,
    output logic               fuse_strobe,
    output logic               fuse_prog_en,
    output logic [31:0]        fuse_wdata,
    input  logic [31:0]        fuse_rdata
);
    import fuse_ctl_pkg::*;

    typedef struct packed {
        logic [15:0]        key;
        logic [FADDR_W-1:0] addr;
        logic               err;
        logic [RSTB_W-1:0]  trd;
        logic [RELAX_W-1:0] trx;
        logic [PSTB_W-1:0]  tpg;
        logic [31:0]        pdata;
        logic [31:0]        sdata;
        logic [31:0]        rdata;
    } regs_s;

    regs_s st_d, st_q;

    logic wr_ctrl, wr_set, wr_clr, wr_tim, sense_req, prog_req;
    logic start_sense, start_prog, err_set;
    logic busy, seq_capture, seq_done;
    logic [PSTB_W-1:0] seq_stb;
    logic [31:0] ctrl_view, tim_view, rd_mux;

    always_comb begin
        wr_ctrl   = bus_wr && (bus_waddr == BUS_AW'(OFS_CTRL));
        wr_set    = bus_wr && (bus_waddr == BUS_AW'(OFS_SET));
        wr_clr    = bus_wr && (bus_waddr == BUS_AW'(OFS_CLR));
        wr_tim    = bus_wr && (bus_waddr == BUS_AW'(OFS_TIMING));
        sense_req = bus_wr && (bus_waddr == BUS_AW'(OFS_RDCTL)) && bus_wdata[0];
        prog_req  = bus_wr && (bus_waddr == BUS_AW'(OFS_PDATA));
    end

    fuse_req_gate i_gate (
        .busy_i        (busy),
        .key_ok_i      (st_q.key == UNLOCK_KEY),
        .sense_req_i   (sense_req),
        .prog_req_i    (prog_req),
        .start_sense_o (start_sense),
        .start_prog_o  (start_prog),
        .err_set_o     (err_set)
    );

    assign seq_stb = start_prog ? st_q.tpg : PSTB_W'(st_q.trd);

    fuse_phase_seq #(
        .RELAX_W (RELAX_W),
        .STB_W   (PSTB_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_sense || start_prog),
        .prog_i    (start_prog),
        .relax_i   (st_q.trx),
        .stb_i     (seq_stb),
        .busy_o    (busy),
        .strobe_o  (fuse_strobe),
        .prog_en_o (fuse_prog_en),
        .capture_o (seq_capture),
        .done_o    (seq_done)
    );

    always_comb begin
        ctrl_view                     = '0;
        ctrl_view[KEY_LSB +: 16]      = st_q.key;
        ctrl_view[ERR_BIT]            = st_q.err;
        ctrl_view[BUSY_BIT]           = busy;
        ctrl_view[FADDR_W-1:0]        = st_q.addr;

        tim_view                      = '0;
        tim_view[TRD_LSB +: RSTB_W]   = st_q.trd;
        tim_view[TRX_LSB +: RELAX_W]  = st_q.trx;
        tim_view[PSTB_W-1:0]          = st_q.tpg;

        case (bus_raddr)
            BUS_AW'(OFS_CTRL),
            BUS_AW'(OFS_SET),
            BUS_AW'(OFS_CLR):    rd_mux = ctrl_view;
            BUS_AW'(OFS_TIMING): rd_mux = tim_view;
            BUS_AW'(OFS_RDATA):  rd_mux = st_q.sdata;
            default:             rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            if (wr_ctrl) begin
                st_d.key  = bus_wdata[KEY_LSB +: 16];
                st_d.addr = bus_wdata[FADDR_W-1:0];
            end
            if (wr_set) begin
                st_d.key  = st_q.key  | bus_wdata[KEY_LSB +: 16];
                st_d.addr = st_q.addr | bus_wdata[FADDR_W-1:0];
            end
            if (wr_clr) begin
                st_d.key  = st_q.key  & ~bus_wdata[KEY_LSB +: 16];
                st_d.addr = st_q.addr & ~bus_wdata[FADDR_W-1:0];
            end
            if (wr_tim) begin
                st_d.trd = bus_wdata[TRD_LSB +: RSTB_W];
                st_d.trx = bus_wdata[TRX_LSB +: RELAX_W];
                st_d.tpg = bus_wdata[PSTB_W-1:0];
            end
        end
        if (wr_clr && bus_wdata[ERR_BIT]) st_d.err = 1'b0;
        if (err_set)                      st_d.err = 1'b1;
        if (start_prog)                   st_d.pdata = bus_wdata;
        if (seq_capture)                  st_d.sdata = fuse_rdata;
        if (seq_done)                     st_d.key = '0;
        if (bus_rd)                       st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign fuse_addr  = st_q.addr;
    assign fuse_wdata = st_q.pdata;

    assert_prog_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !busy && st_q.key == UNLOCK_KEY) |=> (busy && fuse_prog_en));

    assert_locked_no_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !busy && st_q.key != UNLOCK_KEY) |=> (!busy && st_q.err));

    assert_busy_req_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_req || prog_req) && busy) |=> st_q.err);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[ERR_BIT]) |=> !st_q.err);

    assert_key_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_q.key == '0));

    assert_fields_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(st_q.addr) && $stable(st_q.tpg) && $stable(st_q.pdata)));

endmodule

// File: tb/test_otp_fuse_ctl.sv
module test_otp_fuse_ctl;
    import fuse_ctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  fuse_addr;
    logic        fuse_strobe, fuse_prog_en;
    logic [31:0] fuse_wdata, fuse_rdata;

    logic [31:0] fuse_mem [128];
    logic [31:0] ref_mem  [128];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    otp_fuse_ctl i_otp_fuse_ctl (
        .clk, .rst_n, .bus_wr, .bus_waddr, .bus_wdata, .bus_rd, .bus_raddr,
        .bus_rdata, .fuse_addr, .fuse_strobe, .fuse_prog_en, .fuse_wdata, .fuse_rdata
    );

    // behavioural fuse array: bits only go from 0 to 1
    assign fuse_rdata = fuse_mem[fuse_addr];
    always @(posedge clk)
        if (fuse_strobe && fuse_prog_en)
            fuse_mem[fuse_addr] <= fuse_mem[fuse_addr] | fuse_wdata;

    function automatic logic [31:0] init_word(int a);
        return 32'((a + 1) * 32'h0101_0011);
    endfunction

    function automatic int calc_w(int r, int s);
        int tot = s + 1;
        int two = 2 * (r + 1);
        return (tot > two) ? tot - two : 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_raddr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // start an operation and measure it; busy is observed through polled
    // control reads, which lag the strobe pins by one cycle
    task automatic run_op(input logic [7:0] ta, input logic [31:0] td,
                          input int inj_at, input logic [7:0] ia, input logic [31:0] id,
                          input logic [31:0] exp_wd,
                          output int nb, output int first_st, output int nst,
                          output int pe_cnt, output int wd_bad);
        logic prev_st, prev_pe;
        logic [31:0] prev_wd;
        nb = 0; first_st = -1; nst = 0; pe_cnt = 0; wd_bad = 0;
        bus_wr = 1'b1; bus_waddr = ta; bus_wdata = td;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1; bus_raddr = OFS_CTRL;
        prev_st = fuse_strobe; prev_pe = fuse_prog_en; prev_wd = fuse_wdata;
        for (int k = 1; k < 3000; k++) begin
            if (k - 1 == inj_at) begin
                bus_wr = 1'b1; bus_waddr = ia; bus_wdata = id;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
            bus_wr = 1'b0;
            if (!bus_rdata[BUSY_BIT]) break;
            nb++;
            if (prev_st) begin
                if (first_st < 0) first_st = nb - 1;
                nst++;
                if (prev_pe && prev_wd !== exp_wd) wd_bad++;
            end
            if (prev_pe) pe_cnt++;
            prev_st = fuse_strobe; prev_pe = fuse_prog_en; prev_wd = fuse_wdata;
        end
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int nb, fs, ns, pe, wb, w;
        int svals[4] = '{0, 3, 9, 63};
        int pvals[3] = '{2, 10, 40};

        for (int a = 0; a < 128; a++) begin
            fuse_mem[a] = init_word(a);
            ref_mem[a]  = init_word(a);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 strobe", 32'(fuse_strobe), 0);
        chk("R1 prog_en", 32'(fuse_prog_en), 0);
        rd(OFS_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(OFS_TIMING, v); chk("R1 timing", v, 0);
        rd(OFS_RDATA, v);  chk("R1 rdata", v, 0);

        // R2 / R3 field layout
        wr(OFS_CTRL, 32'hFFFF_FFFF);
        rd(OFS_CTRL, v); chk("R2 ctrl layout", v, 32'hFFFF_007F);
        rd(OFS_SET, v);  chk("R2 alias read", v, 32'hFFFF_007F);
        wr(OFS_TIMING, 32'hFFFF_FFFF);
        rd(OFS_TIMING, v); chk("R3 timing layout", v, 32'h003F_FFFF);

        // R11 set/clear aliases
        wr(OFS_CTRL, 32'h0);
        wr(OFS_SET, 32'h3E00_0005);
        wr(OFS_SET, 32'h0077_0000);
        rd(OFS_CTRL, v); chk("R11 set alias", v, 32'h3E77_0005);
        wr(OFS_CLR, 32'h0000_0001);
        rd(OFS_CTRL, v); chk("R11 clear addr bit", v, 32'h3E77_0004);
        wr(OFS_CLR, 32'hFFFF_0000);
        rd(OFS_CTRL, v); chk("R11 clear key", v, 32'h0000_0004);

        // R4 bit 0 clear starts nothing
        wr(OFS_TIMING, 32'h0003_1000);
        wr(OFS_RDCTL, 32'h0000_0002);
        chk("R4 no-op strobe", 32'(fuse_strobe), 0);
        rd(OFS_CTRL, v); chk("R4 no-op busy", 32'(v[BUSY_BIT]), 0);

        // R4 / R5 sense sweep, including clamped active width
        for (int r = 0; r < 4; r++) begin
            for (int si = 0; si < 4; si++) begin
                int s = svals[si];
                int a = ((r * 4 + si) * 9) % 128;
                wr(OFS_TIMING, 32'((s << 16) | (r << 12)));
                wr(OFS_CTRL, 32'(a));
                run_op(OFS_RDCTL, 32'h1, -1, 8'h0, 32'h0, 32'h0, nb, fs, ns, pe, wb);
                w = calc_w(r, s);
                chk("R4 busy length", 32'(nb), 32'(2 * (r + 1) + w));
                chk("R4 strobe lead", 32'(fs), 32'(r + 1));
                chk("R4 strobe width", 32'(ns), 32'(w));
                chk("R4 no prog_en", 32'(pe), 0);
                rd(OFS_RDATA, v); chk("R5 sensed word", v, ref_mem[a]);
            end
        end

        // R6 / R10 program sweep
        for (int r = 0; r < 3; r++) begin
            for (int si = 0; si < 3; si++) begin
                int a = 64 + r * 5 + si * 17;
                logic [31:0] val = (32'h1 << (r * 5 + si * 2 + 3)) | (32'h8000_0000 >> (si + r));
                int s = pvals[si];
                wr(OFS_TIMING, 32'((3 << 16) | (r << 12) | s));
                wr(OFS_CTRL, {UNLOCK_KEY, 16'(a)});
                run_op(OFS_PDATA, val, -1, 8'h0, 32'h0, val, nb, fs, ns, pe, wb);
                ref_mem[a] = ref_mem[a] | val;
                w = calc_w(r, s);
                chk("R6 busy length", 32'(nb), 32'(2 * (r + 1) + w));
                chk("R6 strobe lead", 32'(fs), 32'(r + 1));
                chk("R6 strobe width", 32'(ns), 32'(w));
                chk("R6 prog_en whole op", 32'(pe), 32'(nb));
                chk("R6 write data", 32'(wb), 0);
                rd(OFS_CTRL, v); chk("R10 key wiped", v, 32'(a));
                run_op(OFS_RDCTL, 32'h1, -1, 8'h0, 32'h0, 32'h0, nb, fs, ns, pe, wb);
                rd(OFS_RDATA, v); chk("R6 OR into word", v, ref_mem[a]);
            end
        end

        // R10 key wiped after a sense as well
        wr(OFS_TIMING, 32'h0003_0000);
        wr(OFS_CTRL, {UNLOCK_KEY, 16'd12});
        run_op(OFS_RDCTL, 32'h1, -1, 8'h0, 32'h0, 32'h0, nb, fs, ns, pe, wb);
        rd(OFS_CTRL, v); chk("R10 key wiped after sense", v, 32'd12);

        // R7 locked program
        wr(OFS_CTRL, {16'h3E76, 16'd33});
        wr(OFS_PDATA, 32'hFFFF_FFFF);
        chk("R7 no prog_en", 32'(fuse_prog_en), 0);
        rd(OFS_CTRL, v); chk("R7 error set, idle", v, {16'h3E76, 16'h0200 | 16'd33});
        run_op(OFS_RDCTL, 32'h1, -1, 8'h0, 32'h0, 32'h0, nb, fs, ns, pe, wb);
        rd(OFS_RDATA, v); chk("R7 word unchanged", v, ref_mem[33]);

        // R9 error stickiness and clearing
        wr(OFS_CTRL, 32'h0000_0221);
        rd(OFS_CTRL, v); chk("R9 base write keeps error", v, 32'h0000_0221);
        wr(OFS_CLR, 32'h0000_0200);
        rd(OFS_CTRL, v); chk("R9 clear alias", v, 32'h0000_0021);

        // R8 sense request during a sense
        wr(OFS_TIMING, 32'h0014_2000);
        run_op(OFS_RDCTL, 32'h1, 3, OFS_RDCTL, 32'h1, 32'h0, nb, fs, ns, pe, wb);
        chk("R8 length kept (sense)", 32'(nb), 32'(6 + calc_w(2, 20)));
        rd(OFS_CTRL, v); chk("R8 error (sense)", 32'(v[ERR_BIT]), 1);
        wr(OFS_CLR, 32'h0000_0200);

        // R8 program request during a program
        begin
            logic [31:0] val = 32'h0000_F000;
            wr(OFS_TIMING, 32'h0003_101E);
            wr(OFS_CTRL, {UNLOCK_KEY, 16'd40});
            run_op(OFS_PDATA, val, 2, OFS_PDATA, 32'hFFFF_FFFF, val, nb, fs, ns, pe, wb);
            ref_mem[40] = ref_mem[40] | val;
            chk("R8 length kept (prog)", 32'(nb), 32'(4 + calc_w(1, 30)));
            chk("R8 write data kept", 32'(wb), 0);
            rd(OFS_CTRL, v); chk("R8 error (prog)", 32'(v[ERR_BIT]), 1);
            wr(OFS_CLR, 32'h0000_0200);
            run_op(OFS_RDCTL, 32'h1, -1, 8'h0, 32'h0, 32'h0, nb, fs, ns, pe, wb);
            rd(OFS_RDATA, v); chk("R8 word gets first value only", v, ref_mem[40]);
        end

        // R12 control and timing writes ignored while busy
        wr(OFS_TIMING, 32'h0014_1000);
        wr(OFS_CTRL, 32'd50);
        run_op(OFS_RDCTL, 32'h1, 2, OFS_CTRL, {UNLOCK_KEY, 16'd7}, 32'h0, nb, fs, ns, pe, wb);
        rd(OFS_CTRL, v); chk("R12 ctrl write ignored", v, 32'd50);
        rd(OFS_RDATA, v); chk("R12 sensed old address", v, ref_mem[50]);
        run_op(OFS_RDCTL, 32'h1, 2, OFS_TIMING, 32'h0, 32'h0, nb, fs, ns, pe, wb);
        rd(OFS_TIMING, v); chk("R12 timing write ignored", v, 32'h0014_1000);
        run_op(OFS_RDCTL, 32'h1, 2, OFS_SET, 32'h0000_0001, 32'h0, nb, fs, ns, pe, wb);
        rd(OFS_CTRL, v); chk("R12 set alias ignored", v, 32'd50);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule